// File: doc/BRIEF.md
# Banked Memory Write Address Router

This block sits between a 16-bit host bus and a group of on-chip memories. It receives single-word writes and reads. The top two address bits pick a bank and the other bits give the offset inside that bank. Each write then becomes one strobe, with its own address, into exactly one memory.

There are four banks:
- The control bank holds a main register file, which lives inside the router, and a separate clock-reconfiguration area.
- The modulation bank has two buffers, used as a double buffer.
- The duty lookup table is organised in pages.
- The pattern bank has two buffers, each organised in pages.

Registers in the main file choose which modulation or pattern buffer receives writes, and which duty or pattern page is written. A host therefore sets these registers first and then streams data words into the chosen buffer or page.

Only the main register file can be read back. Any access that cannot be routed changes no memory and sets a sticky error flag.

Top module: `bank_write_router`

## Requirements
- R1: Address bits [15:14] select the bank (0 = control, 1 = modulation, 2 = duty table, 3 = pattern) and bits [13:0] are the offset; a write strobes only outputs belonging to the selected bank, in the same cycle as `wr_en`.
- R2: In the control bank, offset bits [13:8] equal to 0 write main register offset[7:0]; equal to 1 pulse `clk_cfg_we` with `clk_cfg_addr` = offset[7:0]; any other value is an illegal access.
- R3: A modulation-bank write pulses `mod_we[s]` with `mod_addr` = offset[13:0], where s is the value of main register 0x20. A value above 1 makes the write illegal.
- R4: A duty-bank write pulses `duty_we` with `duty_addr` = {p[1:0], offset[13:0]}, where p is main register 0x21. A value of p above 3 makes the write illegal.
- R5: A pattern-bank write pulses `pat_we[s]` with `pat_addr` = {p[3:0], offset[13:0]}, where s is main register 0x22 and p is main register 0x23. A value of s above 1, or of p above 15, makes the write illegal.
- R6: A segment or page register written in one cycle already steers a write in the very next cycle.
- R7: A read of the main register file returns, on `rdata` one clock after `rd_en`, the word stored before any write in the same cycle. A read of the clock-reconfiguration area or of any other bank is illegal and returns 0.
- R8: An illegal access asserts no write strobe and changes no register. It sets `err` from the next clock on, and `err` stays set until reset.
- R9: At most one write strobe is active per cycle, none is active while `wr_en` is low, and `mem_wdata` equals `wdata`.
- R10: After reset, every main register reads 0 and both `err` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 16 | Host address: bank [15:14], offset [13:0] |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered read data |
| err | output | 1 | Sticky illegal-access flag |
| mem_wdata | output | 16 | Write data to all memories |
| clk_cfg_we | output | 1 | Clock-reconfiguration area write strobe |
| clk_cfg_addr | output | 8 | Clock-reconfiguration area word address |
| mod_we | output | 2 | Modulation buffer write strobes, one per buffer |
| mod_addr | output | 14 | Modulation buffer word address |
| duty_we | output | 1 | Duty table write strobe |
| duty_addr | output | 16 | Duty table word address {page, offset} |
| pat_we | output | 2 | Pattern buffer write strobes, one per buffer |
| pat_addr | output | 18 | Pattern buffer word address {page, offset} |

## Verification
The assertions watch properties that must hold on every cycle:
- the strobes are one-hot or idle, and fall silent when no write is requested;
- a strobe never fires for a bank other than the one addressed;
- the error flag stays set once raised, and rises only after an access;
- an illegal read leaves a zero;
- a segment register write is visible on the next cycle.

The bench scenarios are needed to show that each bank receives the exact concatenated address, and that a segment or page change steers the very next write. They also cover read-before-write ordering on a read and write to the same register, and the point at which each limit on segment and page values becomes illegal. Finally, they show that an ignored access leaves the register file unchanged when read back.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
   localparam int BANK_W = 2;

   typedef enum logic [BANK_W-1:0] {
      BANK_CTRL = 2'd0,
      BANK_MOD  = 2'd1,
      BANK_DUTY = 2'd2,
      BANK_PAT  = 2'd3
   } bank_e;

   typedef enum logic [1:0] {
      SUB_MAIN = 2'd0,
      SUB_CLK  = 2'd1,
      SUB_BAD  = 2'd2
   } sub_e;
endpackage

// File: rtl/bwr_decode.sv
module bwr_decode
   import bwr_pkg::*;
#(
   parameter int OFF_W   = 14,
   parameter int CTRL_AW = 8,
   localparam int ADDR_W = BANK_W + OFF_W,
   localparam int SEL_W  = OFF_W - CTRL_AW
) (
   input  logic [ADDR_W-1:0] addr,
   output bank_e             bank,
   output logic [OFF_W-1:0]  off,
   output sub_e              sub
);
   generate
      if (SEL_W < 1) begin : g_bad_split
         $error("control area selector needs at least one bit");
      end
   endgenerate

   logic [SEL_W-1:0] sel;

   always_comb begin
      bank = bank_e'(addr[ADDR_W-1:OFF_W]);
      off  = addr[OFF_W-1:0];
      sel  = off[OFF_W-1:CTRL_AW];
      if (sel == '0)
         sub = SUB_MAIN;
      else if (sel == SEL_W'(1))
         sub = SUB_CLK;
      else
         sub = SUB_BAD;
   end
endmodule

// File: rtl/bwr_ctrl_file.sv
module bwr_ctrl_file #(
   parameter int DATA_W        = 16,
   parameter int AW            = 8,
   parameter int MOD_SEG_REG   = 32,
   parameter int DUTY_PAGE_REG = 33,
   parameter int PAT_SEG_REG   = 34,
   parameter int PAT_PAGE_REG  = 35,
   localparam int DEPTH        = 2 ** AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic              rd_ok,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] mod_seg,
   output logic [DATA_W-1:0] duty_page,
   output logic [DATA_W-1:0] pat_seg,
   output logic [DATA_W-1:0] pat_page
);
   generate
      if (MOD_SEG_REG >= DEPTH || DUTY_PAGE_REG >= DEPTH ||
          PAT_SEG_REG >= DEPTH || PAT_PAGE_REG >= DEPTH) begin : g_bad_reg
         $error("steering register offset outside the register file");
      end
   endgenerate

   logic [DATA_W-1:0] regs [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (re)
         rdata <= rd_ok ? regs[raddr] : '0;
   end

   assign mod_seg   = regs[MOD_SEG_REG];
   assign duty_page = regs[DUTY_PAGE_REG];
   assign pat_seg   = regs[PAT_SEG_REG];
   assign pat_page  = regs[PAT_PAGE_REG];

   // R6: a segment register write is visible to the steering on the next cycle
   a_r6_seg_next: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == AW'(MOD_SEG_REG)) |=> (mod_seg == $past(wdata)));

   // R7: an illegal read leaves zero on the read port
   a_r7_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (re && !rd_ok) |=> (rdata == '0));
endmodule

// File: rtl/bwr_seg_steer.sv
module bwr_seg_steer #(
   parameter int NUM_SEG = 2,
   parameter int PAGE_W  = 0,
   parameter int OFF_W   = 14,
   parameter int DATA_W  = 16,
   localparam int OUT_W  = PAGE_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [DATA_W-1:0]  seg_val,
   input  logic [DATA_W-1:0]  page_val,
   input  logic [OFF_W-1:0]   off,
   output logic [NUM_SEG-1:0] we,
   output logic [OUT_W-1:0]   waddr,
   output logic               illegal
);
   generate
      if (NUM_SEG < 1 || NUM_SEG > 2 ** DATA_W) begin : g_bad_seg
         $error("segment count out of range");
      end
      if (PAGE_W < 0 || PAGE_W >= DATA_W) begin : g_bad_page
         $error("page width out of range");
      end
   endgenerate

   logic seg_ok;
   logic page_ok;
   logic route_ok;

   assign seg_ok   = seg_val < DATA_W'(NUM_SEG);
   assign page_ok  = (page_val >> PAGE_W) == '0;
   assign route_ok = seg_ok && page_ok;
   assign illegal  = req && !route_ok;

   generate
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
         assign we[s] = req && route_ok && (seg_val == DATA_W'(s));
      end
      if (PAGE_W == 0) begin : g_flat
         assign waddr = off;
      end else begin : g_paged
         assign waddr = {page_val[PAGE_W-1:0], off};
      end
   endgenerate

   // R9: never more than one buffer of a pair strobed
   a_r9_one_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we));

   // R8: a rejected request strobes no buffer
   a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (we == '0));
endmodule

// File: rtl/bank_write_router.sv
module bank_write_router
   import bwr_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int OFF_W         = 14,
   parameter int CTRL_AW       = 8,
   parameter int DUTY_PAGE_W   = 2,
   parameter int PAT_PAGE_W    = 4,
   parameter int MOD_SEG_REG   = 32,
   parameter int DUTY_PAGE_REG = 33,
   parameter int PAT_SEG_REG   = 34,
   parameter int PAT_PAGE_REG  = 35,
   localparam int ADDR_W       = BANK_W + OFF_W,
   localparam int MOD_AW       = OFF_W,
   localparam int DUTY_AW      = OFF_W + DUTY_PAGE_W,
   localparam int PAT_AW       = OFF_W + PAT_PAGE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               err,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               clk_cfg_we,
   output logic [CTRL_AW-1:0] clk_cfg_addr,
   output logic [1:0]         mod_we,
   output logic [MOD_AW-1:0]  mod_addr,
   output logic               duty_we,
   output logic [DUTY_AW-1:0] duty_addr,
   output logic [1:0]         pat_we,
   output logic [PAT_AW-1:0]  pat_addr
);
   generate
      if (ADDR_W != 16 || DATA_W < 1) begin : g_bad_bus
         $error("host bus must carry a 16-bit address");
      end
   endgenerate

   bank_e              bank;
   sub_e               sub;
   logic [OFF_W-1:0]   off;
   logic [DATA_W-1:0]  mod_seg, duty_page, pat_seg, pat_page;
   logic               wr_ctrl, ctrl_we, ctrl_bad;
   logic               mod_ill, duty_ill, pat_ill;
   logic               rd_ok, rd_bad, wr_bad;
   logic [0:0]         duty_we_v;

   bwr_decode #(.OFF_W(OFF_W), .CTRL_AW(CTRL_AW)) u_decode (
      .addr (addr),
      .bank (bank),
      .off  (off),
      .sub  (sub)
   );

   assign wr_ctrl    = wr_en && (bank == BANK_CTRL);
   assign ctrl_we    = wr_ctrl && (sub == SUB_MAIN);
   assign clk_cfg_we = wr_ctrl && (sub == SUB_CLK);
   assign ctrl_bad   = wr_ctrl && (sub == SUB_BAD);
   assign rd_ok      = (bank == BANK_CTRL) && (sub == SUB_MAIN);
   assign rd_bad     = rd_en && !rd_ok;

   bwr_ctrl_file #(
      .DATA_W(DATA_W), .AW(CTRL_AW),
      .MOD_SEG_REG(MOD_SEG_REG), .DUTY_PAGE_REG(DUTY_PAGE_REG),
      .PAT_SEG_REG(PAT_SEG_REG), .PAT_PAGE_REG(PAT_PAGE_REG)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ctrl_we),
      .waddr     (off[CTRL_AW-1:0]),
      .wdata     (wdata),
      .re        (rd_en),
      .rd_ok     (rd_ok),
      .raddr     (off[CTRL_AW-1:0]),
      .rdata     (rdata),
      .mod_seg   (mod_seg),
      .duty_page (duty_page),
      .pat_seg   (pat_seg),
      .pat_page  (pat_page)
   );

   bwr_seg_steer #(.NUM_SEG(2), .PAGE_W(0), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_mod (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (wr_en && (bank == BANK_MOD)),
      .seg_val  (mod_seg),
      .page_val ('0),
      .off      (off),
      .we       (mod_we),
      .waddr    (mod_addr),
      .illegal  (mod_ill)
   );

   bwr_seg_steer #(.NUM_SEG(1), .PAGE_W(DUTY_PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_duty (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (wr_en && (bank == BANK_DUTY)),
      .seg_val  ('0),
      .page_val (duty_page),
      .off      (off),
      .we       (duty_we_v),
      .waddr    (duty_addr),
      .illegal  (duty_ill)
   );
   assign duty_we = duty_we_v[0];

   bwr_seg_steer #(.NUM_SEG(2), .PAGE_W(PAT_PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_pat (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (wr_en && (bank == BANK_PAT)),
      .seg_val  (pat_seg),
      .page_val (pat_page),
      .off      (off),
      .we       (pat_we),
      .waddr    (pat_addr),
      .illegal  (pat_ill)
   );

   assign clk_cfg_addr = off[CTRL_AW-1:0];
   assign mem_wdata    = wdata;
   assign wr_bad       = ctrl_bad || mod_ill || duty_ill || pat_ill;

   always_ff @(posedge clk) begin
      if (!rst_n)
         err <= 1'b0;
      else if (wr_bad || rd_bad)
         err <= 1'b1;
   end

   // R9: at most one write strobe per cycle
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctrl_we, clk_cfg_we, mod_we, duty_we, pat_we}));

   // R9: no strobe without a host write
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> ({clk_cfg_we, mod_we, duty_we, pat_we} == '0));

   // R1: a strobe only fires for the bank named by the address
   a_r1_bank_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_we != '0 || duty_we || pat_we != '0) |-> (addr[ADDR_W-1:OFF_W] != '0));

   // R8: the error flag stays set
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R8: the error flag rises only after an access
   a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(wr_en || rd_en));
endmodule

// File: tb/bank_write_router_test.sv
module bank_write_router_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata, mem_wdata;
   logic        err, clk_cfg_we, duty_we;
   logic [7:0]  clk_cfg_addr;
   logic [1:0]  mod_we, pat_we;
   logic [13:0] mod_addr;
   logic [15:0] duty_addr;
   logic [17:0] pat_addr;

   always #2 clk = ~clk;

   bank_write_router uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .err(err), .mem_wdata(mem_wdata),
      .clk_cfg_we(clk_cfg_we), .clk_cfg_addr(clk_cfg_addr),
      .mod_we(mod_we), .mod_addr(mod_addr), .duty_we(duty_we),
      .duty_addr(duty_addr), .pat_we(pat_we), .pat_addr(pat_addr)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic        clk_we;
      logic [7:0]  clk_a;
      logic [1:0]  mod_w;
      logic [13:0] mod_a;
      logic        duty_w;
      logic [15:0] duty_a;
      logic [1:0]  pat_w;
      logic [17:0] pat_a;
      logic [15:0] wd;
      logic        rd_chk;
      logic [15:0] rd_v;
      logic        err_v;
   } item_t;

   item_t       exp_q[$];
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;
   logic [15:0] model [256];
   logic        err_m = 1'b0;
   logic        pend_chk = 1'b0;
   logic [15:0] pend_v = '0;

   task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // Monitor: pops one expected item per cycle and compares with the outputs.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         check(int'(it.req), "clk_cfg_we", 32'(clk_cfg_we), 32'(it.clk_we));
         check(int'(it.req), "mod_we", 32'(mod_we), 32'(it.mod_w));
         check(int'(it.req), "duty_we", 32'(duty_we), 32'(it.duty_w));
         check(int'(it.req), "pat_we", 32'(pat_we), 32'(it.pat_w));
         check(int'(it.req), "err", 32'(err), 32'(it.err_v));
         if (it.clk_we) check(int'(it.req), "clk_cfg_addr", 32'(clk_cfg_addr), 32'(it.clk_a));
         if (it.mod_w != 0) check(int'(it.req), "mod_addr", 32'(mod_addr), 32'(it.mod_a));
         if (it.duty_w) check(int'(it.req), "duty_addr", 32'(duty_addr), 32'(it.duty_a));
         if (it.pat_w != 0) check(int'(it.req), "pat_addr", 32'(pat_addr), 32'(it.pat_a));
         if (it.clk_we || it.mod_w != 0 || it.duty_w || it.pat_w != 0)
            check(9, "mem_wdata", 32'(mem_wdata), 32'(it.wd));   // R9
         if (it.rd_chk) check(int'(it.req), "rdata", 32'(rdata), 32'(it.rd_v));
      end
   end

   task automatic model_clear();
      for (int i = 0; i < 256; i++) model[i] = '0;
      err_m = 1'b0;
      pend_chk = 1'b0;
      pend_v = '0;
   endtask

   // Driver: applies one cycle of stimulus and pushes what it must produce.
   task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                       input logic [15:0] d, input int req);
      item_t it;
      logic [1:0]  bank;
      logic [13:0] off;
      logic        bad;
      logic [15:0] s, p;
      @(posedge clk);
      #1;
      wr_en = wr; rd_en = rd; addr = a; wdata = d;
      bank = a[15:14]; off = a[13:0]; bad = 1'b0;
      it = '0;
      it.req = 8'(req); it.wd = d; it.err_v = err_m;
      it.rd_chk = pend_chk; it.rd_v = pend_v;
      if (wr) begin
         case (bank)
            2'd0: begin
               if (off[13:8] == 6'd1) begin it.clk_we = 1'b1; it.clk_a = off[7:0]; end
               else if (off[13:8] != 6'd0) bad = 1'b1;
            end
            2'd1: begin
               s = model[8'h20];
               if (s < 2) begin it.mod_w = (s == 0) ? 2'b01 : 2'b10; it.mod_a = off; end
               else bad = 1'b1;
            end
            2'd2: begin
               p = model[8'h21];
               if (p < 4) begin it.duty_w = 1'b1; it.duty_a = {p[1:0], off}; end
               else bad = 1'b1;
            end
            default: begin
               s = model[8'h22]; p = model[8'h23];
               if (s < 2 && p < 16) begin
                  it.pat_w = (s == 0) ? 2'b01 : 2'b10; it.pat_a = {p[3:0], off};
               end else bad = 1'b1;
            end
         endcase
      end
      pend_chk = rd;
      if (rd) begin
         if (bank == 2'd0 && off[13:8] == 6'd0) pend_v = model[off[7:0]];
         else begin pend_v = '0; bad = 1'b1; end
      end
      exp_q.push_back(it);
      if (wr && bank == 2'd0 && off[13:8] == 6'd0) model[off[7:0]] = d;
      if (bad) err_m = 1'b1;
   endtask

   task automatic idle(input int n, input int req);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0000, 16'h0000, req);
   endtask

   task automatic do_reset();
      idle(2, 10);
      wait (exp_q.size() == 0);
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
      model_clear();
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(10, "rdata after reset", 32'(rdata), 32'h0);
      check(10, "err after reset", 32'(err), 32'h0);
      step(1'b0, 1'b1, 16'h0020, 16'h0, 10);
      step(1'b0, 1'b1, 16'h0023, 16'h0, 10);
      // R2: main register write and readback; R7: read-before-write ordering
      step(1'b1, 1'b0, 16'h0005, 16'hA5A5, 2);
      step(1'b1, 1'b1, 16'h0005, 16'h1234, 7);
      step(1'b0, 1'b1, 16'h0005, 16'h0, 7);
      // R2: clock-reconfiguration area
      step(1'b1, 1'b0, 16'h01FE, 16'hBEEF, 2);
      // R1, R3: modulation buffer 0 by default
      step(1'b1, 1'b0, 16'h4123, 16'h0F0F, 3);
      // R6: segment switch steers the very next write
      step(1'b1, 1'b0, 16'h0020, 16'h0001, 6);
      step(1'b1, 1'b0, 16'h7FFF, 16'h5555, 6);
      step(1'b1, 1'b0, 16'h0020, 16'h0000, 6);
      step(1'b1, 1'b0, 16'h4001, 16'h6666, 6);
      // R4: duty table pages
      step(1'b1, 1'b0, 16'h8ABC, 16'h1111, 4);
      step(1'b1, 1'b0, 16'h0021, 16'h0003, 4);
      step(1'b1, 1'b0, 16'h8ABC, 16'h2222, 4);
      // R5: pattern buffers and pages
      step(1'b1, 1'b0, 16'h0022, 16'h0001, 5);
      step(1'b1, 1'b0, 16'h0023, 16'h000F, 5);
      step(1'b1, 1'b0, 16'hC001, 16'h3333, 5);
      step(1'b1, 1'b0, 16'h0022, 16'h0000, 5);
      step(1'b1, 1'b0, 16'h0023, 16'h0005, 5);
      step(1'b1, 1'b0, 16'hFFFF, 16'h4444, 5);
      // R9: no strobe without wr_en
      step(1'b0, 1'b0, 16'h4010, 16'h7777, 9);
      step(1'b0, 1'b0, 16'hC010, 16'h7777, 9);
      // R1: bank bits pick duty table, not pattern
      step(1'b1, 1'b0, 16'hBFFF, 16'h8888, 1);
      idle(2, 8);   // R8: err still low after legal traffic

      // R8: bad control sub-area write is ignored
      do_reset();
      step(1'b1, 1'b0, 16'h0200, 16'hDEAD, 8);
      step(1'b0, 1'b1, 16'h0000, 16'h0, 8);
      idle(2, 8);
      // R3, R8: modulation segment above 1
      do_reset();
      step(1'b1, 1'b0, 16'h0020, 16'h0002, 3);
      step(1'b1, 1'b0, 16'h4004, 16'h1357, 3);
      idle(2, 8);
      // R4, R8: duty page above 3
      do_reset();
      step(1'b1, 1'b0, 16'h0021, 16'h0004, 4);
      step(1'b1, 1'b0, 16'h8004, 16'h2468, 4);
      idle(2, 8);
      // R5, R8: pattern page above 15
      do_reset();
      step(1'b1, 1'b0, 16'h0023, 16'h0010, 5);
      step(1'b1, 1'b0, 16'hC004, 16'h2468, 5);
      idle(2, 8);
      // R7: read of clock area returns 0, after a legal nonzero read
      do_reset();
      step(1'b1, 1'b0, 16'h0007, 16'hCAFE, 7);
      step(1'b0, 1'b1, 16'h0007, 16'h0, 7);
      step(1'b0, 1'b1, 16'h0107, 16'h0, 7);
      idle(2, 7);
      // R7: read of another bank is illegal
      do_reset();
      step(1'b0, 1'b1, 16'h4000, 16'h0, 7);
      idle(2, 7);
      // R10: reset cleared the register set earlier
      do_reset();
      step(1'b0, 1'b1, 16'h0007, 16'h0, 10);
      idle(2, 10);
      wait (exp_q.size() == 0);
      @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL R9 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule